// File: doc/BRIEF.md
# DMA Stream Engine

This block is a single DMA stream. Software sets it up through a small register window: a control word, an element count, a peripheral address and two memory addresses. The block then copies data by mastering a simple single-beat memory bus. Each element takes one read from the source address and then one write to the destination address.

The transfer direction decides when data moves. When data flows from the peripheral to memory, setting the enable bit only arms the stream. After that, each rising edge on the peripheral's request line moves exactly one element. When the last element is written, the stream disarms itself. When data flows from memory to the peripheral, or from memory to memory, setting the enable bit runs the whole block back to back.

In every direction, completion is a one-cycle pulse that a neighbouring block uses to set a status flag. The interrupt-enable bit is brought out so that the same neighbour can decide whether to raise an interrupt.

Top module: `dma_stream_engine`

## Requirements
- R1: The register window has five offsets: 0x00 control, 0x04 element count, 0x08 peripheral address, 0x0C memory address A, 0x10 memory address B. A write is stored. The value at the offset presented in one cycle appears on `reg_rdata` after the next clock edge.
- R2: Control word fields:
  - bit 0: enable
  - bit 4: completion-interrupt enable
  - bits 7:6: direction
  - bit 9: peripheral-side increment
  - bit 10: memory-side increment
  - bits 12:11: peripheral element size
  - bits 14:13: memory element size
  - bits 17:16: priority (stored and read back only)
  - bits 27:25: channel (stored and read back only)

  Reading the control word always returns 0 in bit 0. A size code of 3 is stored as 0 and reads back as 0.
- R3: After reset, every register reads 0, `irq_en` is 0 and `bus_req` is 0.
- R4: Direction codes and their source/destination mapping:
  - 0, peripheral to memory: source is the peripheral address with the peripheral size and increment; destination is address A with the memory size and increment.
  - 1, memory to peripheral: source is address A with the memory size and increment; destination is the peripheral address with the peripheral size and increment.
  - 2 and 3, memory to memory: source is the peripheral address and destination is address A, both with the memory size and increment.

  Size codes 0, 1 and 2 mean 1, 2 and 4 bytes, and they appear on `bus_size`.
- R5: Each element is one read followed by one write. `bus_req`, `bus_we`, `bus_addr` and `bus_size` hold steady until `bus_ack`. Write data is the read data cut to the source width, then cut to the destination width.
- R6: After an element, an address advances by its own element size in bytes if its increment bit is set. Otherwise it stays the same.
- R7: In directions 1, 2 and 3, a control write with the enable bit set moves all elements back to back, with no request needed.
- R8: In direction 0, a control write with the enable bit set arms the stream. Each low-to-high transition of `periph_req` while armed moves exactly one element; a level held high moves no more. A transition while disarmed has no effect.
- R9: `done` pulses high for exactly one cycle, on the cycle after the final write is acknowledged. After that pulse, a direction-0 stream is disarmed.
- R10: If the element count is zero when enable is written, there is no bus traffic and no `done`.
- R11: `irq_en` equals the stored completion-interrupt enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_OFFS_W | Local register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's offset |
| periph_req | input | 1 | Peripheral request level |
| bus_req | output | 1 | Bus access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte address |
| bus_size | output | 2 | Access size code (0 = byte, 1 = half-word, 2 = word) |
| bus_wdata | output | 32 | Write data, right-justified |
| bus_rdata | input | 32 | Read data, right-justified, valid with bus_ack |
| bus_ack | input | 1 | Access completes in this cycle |
| done | output | 1 | One-cycle completion pulse |
| irq_en | output | 1 | Stored completion-interrupt enable |

## Verification
The bench covers the cases where the two sides of a copy differ:

- A half-word source feeding a byte destination. A design that skipped the width cut would write stray upper bytes.
- A fixed (non-incrementing) address on one side. A design that ignored the increment bit would walk the peripheral address.

The bench also holds the request line high for many cycles. A level-sensitive design would stream extra elements; a design that failed to disarm would keep copying after `done`. Finally, the bench writes enable with a zero count and with a disarmed stream. A wrong design would start bus traffic or raise `done` there.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;

  typedef enum logic [1:0] {
    DIR_P2M = 2'd0,
    DIR_M2P = 2'd1,
    DIR_M2M = 2'd2,
    DIR_RSV = 2'd3
  } dir_e;

  typedef struct packed {
    logic [2:0] chan;
    logic [1:0] prio;
    logic [1:0] msz;
    logic [1:0] psz;
    logic       minc;
    logic       pinc;
    dir_e       dir;
    logic       tcie;
  } cfg_t;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_CNT  = 8'h04;
  localparam logic [7:0] OFF_PADR = 8'h08;
  localparam logic [7:0] OFF_MADA = 8'h0C;
  localparam logic [7:0] OFF_MADB = 8'h10;

  function automatic logic [1:0] legal_size(input logic [1:0] code);
    return (code == 2'd3) ? 2'd0 : code;
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/dma_stream_regs.sv
module dma_stream_regs
  import dma_stream_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int OW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [OW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output cfg_t          cfg,
  output logic [CW-1:0] cnt,
  output logic [AW-1:0] padr,
  output logic [AW-1:0] mada,
  output logic          start
);

  logic [AW-1:0] madb;
  logic [31:0]   ctrl_view;

  always_comb begin
    ctrl_view        = '0;
    ctrl_view[27:25] = cfg.chan;
    ctrl_view[17:16] = cfg.prio;
    ctrl_view[14:13] = cfg.msz;
    ctrl_view[12:11] = cfg.psz;
    ctrl_view[10]    = cfg.minc;
    ctrl_view[9]     = cfg.pinc;
    ctrl_view[7:6]   = cfg.dir;
    ctrl_view[4]     = cfg.tcie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '0;
      cnt   <= '0;
      padr  <= '0;
      mada  <= '0;
      madb  <= '0;
      start <= 1'b0;
    end else begin
      start <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          OW'(OFF_CTRL): begin
            cfg.chan <= reg_wdata[27:25];
            cfg.prio <= reg_wdata[17:16];
            cfg.msz  <= legal_size(reg_wdata[14:13]);
            cfg.psz  <= legal_size(reg_wdata[12:11]);
            cfg.minc <= reg_wdata[10];
            cfg.pinc <= reg_wdata[9];
            cfg.dir  <= dir_e'(reg_wdata[7:6]);
            cfg.tcie <= reg_wdata[4];
            start    <= reg_wdata[0];
          end
          OW'(OFF_CNT):  cnt  <= reg_wdata[CW-1:0];
          OW'(OFF_PADR): padr <= reg_wdata[AW-1:0];
          OW'(OFF_MADA): mada <= reg_wdata[AW-1:0];
          OW'(OFF_MADB): madb <= reg_wdata[AW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        OW'(OFF_CTRL): reg_rdata <= ctrl_view;
        OW'(OFF_CNT):  reg_rdata <= 32'(cnt);
        OW'(OFF_PADR): reg_rdata <= 32'(padr);
        OW'(OFF_MADA): reg_rdata <= 32'(mada);
        OW'(OFF_MADB): reg_rdata <= 32'(madb);
        default:       reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_stream_mover.sv
module dma_stream_mover
  import dma_stream_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  cfg_t          cfg,
  input  logic [CW-1:0] cnt,
  input  logic [AW-1:0] padr,
  input  logic [AW-1:0] mada,
  input  logic          periph_req,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ack,
  output logic          done
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RD, S_WR} st_e;

  st_e           st;
  logic [AW-1:0] src_a, dst_a;
  logic [1:0]    src_sz, dst_sz;
  logic          src_inc, dst_inc, p2m, pend, req_d;
  logic [CW-1:0] left;

  logic          j_p2m, j_m2p;
  logic [AW-1:0] j_src, j_dst;
  logic [1:0]    j_ssz, j_dsz;
  logic          j_sinc, j_dinc;
  logic          req_edge;
  logic [AW-1:0] src_nxt, dst_nxt;

  always_comb begin
    j_p2m    = (cfg.dir == DIR_P2M);
    j_m2p    = (cfg.dir == DIR_M2P);
    j_src    = j_m2p ? mada : padr;
    j_dst    = j_m2p ? padr : mada;
    j_ssz    = j_p2m ? cfg.psz : cfg.msz;
    j_dsz    = j_m2p ? cfg.psz : cfg.msz;
    j_sinc   = j_p2m ? cfg.pinc : cfg.minc;
    j_dinc   = j_m2p ? cfg.pinc : cfg.minc;
    req_edge = periph_req & ~req_d;
    src_nxt  = src_inc ? src_a + AW'(size_bytes(src_sz)) : src_a;
    dst_nxt  = dst_inc ? dst_a + AW'(size_bytes(dst_sz)) : dst_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      src_a     <= '0;
      dst_a     <= '0;
      src_sz    <= '0;
      dst_sz    <= '0;
      src_inc   <= 1'b0;
      dst_inc   <= 1'b0;
      p2m       <= 1'b0;
      pend      <= 1'b0;
      req_d     <= 1'b0;
      left      <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_size  <= '0;
      bus_wdata <= '0;
      done      <= 1'b0;
    end else begin
      done  <= 1'b0;
      req_d <= periph_req;
      case (st)
        S_IDLE: begin
          pend <= 1'b0;
          if (start && cnt != '0) begin
            src_a   <= j_src;
            dst_a   <= j_dst;
            src_sz  <= j_ssz;
            dst_sz  <= j_dsz;
            src_inc <= j_sinc;
            dst_inc <= j_dinc;
            p2m     <= j_p2m;
            left    <= cnt;
            if (j_p2m) begin
              st <= S_WAIT;
            end else begin
              st       <= S_RD;
              bus_req  <= 1'b1;
              bus_we   <= 1'b0;
              bus_addr <= j_src;
              bus_size <= j_ssz;
            end
          end
        end
        S_WAIT: begin
          if (pend || req_edge) begin
            pend     <= 1'b0;
            st       <= S_RD;
            bus_req  <= 1'b1;
            bus_we   <= 1'b0;
            bus_addr <= src_a;
            bus_size <= src_sz;
          end
        end
        S_RD: begin
          if (req_edge && p2m) pend <= 1'b1;
          if (bus_ack) begin
            st        <= S_WR;
            bus_we    <= 1'b1;
            bus_addr  <= dst_a;
            bus_size  <= dst_sz;
            bus_wdata <= bus_rdata & size_mask(src_sz) & size_mask(dst_sz);
          end
        end
        S_WR: begin
          if (req_edge && p2m) pend <= 1'b1;
          if (bus_ack) begin
            src_a  <= src_nxt;
            dst_a  <= dst_nxt;
            left   <= left - 1'b1;
            bus_we <= 1'b0;
            if (left == CW'(1)) begin
              done    <= 1'b1;
              st      <= S_IDLE;
              bus_req <= 1'b0;
            end else if (p2m) begin
              st      <= S_WAIT;
              bus_req <= 1'b0;
            end else begin
              st       <= S_RD;
              bus_addr <= src_nxt;
              bus_size <= src_sz;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_stream_engine.sv
module dma_stream_engine
  import dma_stream_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int REG_OFFS_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic [REG_OFFS_W-1:0] reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  periph_req,
  output logic                  bus_req,
  output logic                  bus_we,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [1:0]            bus_size,
  output logic [31:0]           bus_wdata,
  input  logic [31:0]           bus_rdata,
  input  logic                  bus_ack,
  output logic                  done,
  output logic                  irq_en
);

  cfg_t              cfg;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] padr, mada;
  logic              start;

  dma_stream_regs #(.AW(ADDR_W), .CW(CNT_W), .OW(REG_OFFS_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg(cfg), .cnt(cnt),
    .padr(padr), .mada(mada), .start(start)
  );

  dma_stream_mover #(.AW(ADDR_W), .CW(CNT_W)) u_mover (
    .clk(clk), .rst(rst), .start(start), .cfg(cfg), .cnt(cnt),
    .padr(padr), .mada(mada), .periph_req(periph_req),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .done(done)
  );

  assign irq_en = cfg.tcie;

endmodule

// File: rtl/dma_stream_checker.sv
module dma_stream_checker #(
  parameter int AW = 32,
  parameter int OW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [OW-1:0] reg_addr,
  input logic [31:0]   reg_rdata,
  input logic          bus_req,
  input logic          bus_we,
  input logic          bus_ack,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic          done
);

  p_hold_until_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size)));

  p_write_follows_read_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack && !bus_we) |=> (bus_req && bus_we));

  p_size_legal_r4: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_size != 2'd3));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_write_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(bus_req && bus_ack && bus_we));

  p_enable_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == '0) |=> (reg_rdata[0] == 1'b0));

endmodule

bind dma_stream_engine dma_stream_checker #(.AW(ADDR_W), .OW(REG_OFFS_W)) u_check (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .bus_req(bus_req), .bus_we(bus_we), .bus_ack(bus_ack),
  .bus_addr(bus_addr), .bus_size(bus_size), .done(done)
);

// File: tb/tb_dma_stream_engine.sv
`timescale 1ns/1ps
module tb_dma_stream_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        periph_req = 1'b0;
  logic        bus_req, bus_we, bus_ack, done, irq_en;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;

  always #2.5 clk = ~clk;

  dma_stream_engine dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .done(done), .irq_en(irq_en)
  );

  // ---------------- memory model ----------------
  logic [7:0] mem [0:255];

  function automatic logic [31:0] rd_word(input logic [7:0] a, input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'h0, mem[a]};
      2'd1:    return {16'h0, mem[a+8'd1], mem[a]};
      default: return {mem[a+8'd3], mem[a+8'd2], mem[a+8'd1], mem[a]};
    endcase
  endfunction

  function automatic logic [31:0] mask_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  assign bus_rdata = bus_ack ? rd_word(bus_addr[7:0], bus_size) : 32'h0;

  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0;
    end else begin
      bus_ack <= bus_req && !bus_ack;
      if (bus_req && bus_ack && bus_we) begin
        mem[bus_addr[7:0]] <= bus_wdata[7:0];
        if (bus_size != 2'd0) mem[bus_addr[7:0]+8'd1] <= bus_wdata[15:8];
        if (bus_size == 2'd2) begin
          mem[bus_addr[7:0]+8'd2] <= bus_wdata[23:16];
          mem[bus_addr[7:0]+8'd3] <= bus_wdata[31:24];
        end
      end
    end
  end

  // ---------------- reference model ----------------
  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [1:0]  sz;
    logic [31:0] data;
    bit          last;
    string       tag;
  } txn_t;

  txn_t expq[$];
  int   compared = 0;
  int   mismatched = 0;
  int   done_seen = 0;
  bit   done_due = 1'b0;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    txn_t t;
    if (!rst && !finished) begin
      check(done == done_due, "R9", "done pulse timing", {31'b0, done}, {31'b0, done_due});
      if (done) done_seen++;
      done_due = 1'b0;
      if (bus_req && bus_ack) begin
        if (expq.size() == 0) begin
          check(1'b0, "R10", "unexpected bus access addr", bus_addr, 32'h0);
        end else begin
          t = expq.pop_front();
          check(bus_we == t.we, t.tag, "access direction", {31'b0, bus_we}, {31'b0, t.we});
          check(bus_addr == t.addr, t.tag, "access address", bus_addr, t.addr);
          check(bus_size == t.sz, t.tag, "access size", {30'b0, bus_size}, {30'b0, t.sz});
          if (t.we) check(bus_wdata == t.data, t.tag, "write data", bus_wdata, t.data);
          done_due = t.last;
        end
      end
    end
  end

  // ---------------- tasks ----------------
  function automatic logic [31:0] ctl(input bit en, input bit tcie, input logic [1:0] dir,
                                      input bit pinc, input bit minc,
                                      input logic [1:0] psz, input logic [1:0] msz);
    return {18'b0, msz, psz, minc, pinc, 1'b0, dir, 1'b0, tcie, 3'b0, en};
  endfunction

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic push_elem(input logic [31:0] s, input logic [31:0] d, input logic [1:0] ssz,
                           input logic [1:0] dsz, input bit last, input string tag);
    txn_t t;
    logic [31:0] v;
    v = rd_word(s[7:0], ssz);
    t.we = 1'b0; t.addr = s; t.sz = ssz; t.data = 32'h0; t.last = 1'b0; t.tag = tag;
    expq.push_back(t);
    t.we = 1'b1; t.addr = d; t.sz = dsz; t.data = v & mask_of(dsz); t.last = last;
    expq.push_back(t);
  endtask

  task automatic push_block(input logic [31:0] s, input logic [31:0] d, input logic [1:0] ssz,
                            input logic [1:0] dsz, input bit si, input bit di, input int n,
                            input string tag);
    logic [31:0] sa, da;
    sa = s; da = d;
    for (int i = 0; i < n; i++) begin
      push_elem(sa, da, ssz, dsz, i == n - 1, tag);
      if (si) sa = sa + (32'd1 << ssz);
      if (di) da = da + (32'd1 << dsz);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (expq.size() == 0) break;
    end
    repeat (6) @(negedge clk);
    check(expq.size() == 0, "R7", "pending expected accesses", expq.size(), 0);
  endtask

  task automatic pulse_req(input int hold);
    @(negedge clk);
    periph_req = 1'b1;
    repeat (hold) @(negedge clk);
    periph_req = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] rv;
    int d0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R3 reset state
    reg_read(5'h00, rv); check(rv == 0, "R3", "control after reset", rv, 0);
    reg_read(5'h04, rv); check(rv == 0, "R3", "count after reset", rv, 0);
    reg_read(5'h08, rv); check(rv == 0, "R3", "periph addr after reset", rv, 0);
    reg_read(5'h0C, rv); check(rv == 0, "R3", "mem A after reset", rv, 0);
    check(irq_en == 0 && bus_req == 0, "R3", "irq_en/bus_req after reset", {30'b0, irq_en, bus_req}, 0);

    // R1 register window
    reg_write(5'h04, 32'h0000_1234); reg_read(5'h04, rv); check(rv == 32'h1234, "R1", "count readback", rv, 32'h1234);
    reg_write(5'h08, 32'hDEAD_BEEF); reg_read(5'h08, rv); check(rv == 32'hDEAD_BEEF, "R1", "periph readback", rv, 32'hDEAD_BEEF);
    reg_write(5'h0C, 32'h1357_9BDF); reg_read(5'h0C, rv); check(rv == 32'h1357_9BDF, "R1", "mem A readback", rv, 32'h1357_9BDF);
    reg_write(5'h10, 32'hCAFE_F00D); reg_read(5'h10, rv); check(rv == 32'hCAFE_F00D, "R1", "mem B readback", rv, 32'hCAFE_F00D);

    // R2 field layout, R11 irq_en
    reg_write(5'h00, ctl(0, 1, 2'd1, 1, 0, 2'd2, 2'd1) | (32'd3 << 16) | (32'd5 << 25));
    reg_read(5'h00, rv);
    check(rv == (ctl(0, 1, 2'd1, 1, 0, 2'd2, 2'd1) | (32'd3 << 16) | (32'd5 << 25)), "R2", "control fields", rv,
          ctl(0, 1, 2'd1, 1, 0, 2'd2, 2'd1) | (32'd3 << 16) | (32'd5 << 25));
    check(irq_en == 1'b1, "R11", "irq_en set", {31'b0, irq_en}, 1);
    reg_write(5'h00, ctl(0, 0, 2'd0, 0, 0, 2'd3, 2'd3));
    reg_read(5'h00, rv); check(rv == 0, "R2", "size code 3 reads as byte", rv, 0);
    check(irq_en == 1'b0, "R11", "irq_en clear", {31'b0, irq_en}, 0);

    // R10 zero count: no traffic, no done (direction 0 and 2)
    reg_write(5'h04, 32'd0);
    reg_write(5'h00, ctl(1, 0, 2'd0, 0, 1, 2'd0, 2'd0));
    reg_read(5'h00, rv); check(rv[0] == 1'b0, "R2", "enable reads zero", rv[0], 0);
    d0 = done_seen;
    pulse_req(3);
    reg_write(5'h00, ctl(1, 0, 2'd2, 0, 1, 2'd0, 2'd2));
    repeat (20) @(negedge clk);
    check(done_seen == d0 && bus_req == 0, "R10", "zero count idle", done_seen, d0);

    // R7 R4 R6 memory to memory, words, incrementing
    reg_write(5'h08, 32'h10); reg_write(5'h0C, 32'h80); reg_write(5'h04, 32'd3);
    push_block(32'h10, 32'h80, 2'd2, 2'd2, 1, 1, 3, "R7");
    d0 = done_seen;
    reg_write(5'h00, ctl(1, 0, 2'd2, 0, 1, 2'd0, 2'd2));
    drain();
    check(done_seen == d0 + 1, "R9", "one done per block", done_seen, d0 + 1);

    // R4 R5 R6 memory to peripheral, half-word source, byte fixed destination
    reg_write(5'h0C, 32'h20); reg_write(5'h08, 32'h90); reg_write(5'h04, 32'd4);
    push_block(32'h20, 32'h90, 2'd1, 2'd0, 1, 0, 4, "R5");
    reg_write(5'h00, ctl(1, 1, 2'd1, 0, 1, 2'd0, 2'd1));
    drain();
    check(irq_en == 1'b1, "R11", "irq_en after run", {31'b0, irq_en}, 1);

    // R6 memory to memory with both addresses fixed, bytes
    reg_write(5'h08, 32'h40); reg_write(5'h0C, 32'hA0); reg_write(5'h04, 32'd2);
    push_block(32'h40, 32'hA0, 2'd0, 2'd0, 0, 0, 2, "R6");
    reg_write(5'h00, ctl(1, 0, 2'd2, 0, 0, 2'd0, 2'd0));
    drain();

    // R8 request while disarmed is ignored
    d0 = done_seen;
    pulse_req(3);
    repeat (10) @(negedge clk);
    check(done_seen == d0 && bus_req == 0, "R8", "disarmed request ignored", {31'b0, bus_req}, 0);

    // R8 R9 peripheral to memory, one element per rising edge
    reg_write(5'h08, 32'h30); reg_write(5'h0C, 32'hC0); reg_write(5'h04, 32'd3);
    reg_write(5'h00, ctl(1, 1, 2'd0, 0, 1, 2'd0, 2'd0));
    repeat (8) @(negedge clk);
    check(bus_req == 0, "R8", "armed stream waits for request", {31'b0, bus_req}, 0);
    for (int k = 0; k < 3; k++) begin
      push_elem(32'h30, 32'hC0 + k, 2'd0, 2'd0, k == 2, "R8");
      pulse_req(25);
      drain();
      check(bus_req == 0, "R8", "one element per edge", {31'b0, bus_req}, 0);
    end
    d0 = done_seen;
    pulse_req(3);
    repeat (10) @(negedge clk);
    check(done_seen == d0 && bus_req == 0, "R9", "disarmed after completion", done_seen, d0);

    // R4 R5 peripheral to memory, half-word incrementing source, byte destination
    reg_write(5'h08, 32'h50); reg_write(5'h0C, 32'hD0); reg_write(5'h04, 32'd2);
    reg_write(5'h00, ctl(1, 0, 2'd0, 1, 1, 2'd1, 2'd0));
    repeat (4) @(negedge clk);
    push_elem(32'h50, 32'hD0, 2'd1, 2'd0, 0, "R4");
    pulse_req(2);
    drain();
    push_elem(32'h52, 32'hD1, 2'd1, 2'd0, 1, "R4");
    pulse_req(2);
    drain();

    summary();
  end

endmodule